// File: doc/BRIEF.md
# Slow-Peripheral Wait-State and Strobe Stretcher

This block sits between a 6502-style bus master and one slow peripheral that reacts to reads as well as writes, such as a serial controller. It runs from a clock at twice the CPU cycle rate and generates the CPU phase clock `phi2` from it. Each CPU cycle is therefore one low half followed by one high half. The cycle ends on the falling edge of `phi2`. The block decodes the address against a programmable base and mask. When the peripheral is selected, it pulls `rdy` low so that the CPU repeats the cycle once. During that inserted cycle it drives one unbroken active-low output-enable or write-enable pulse.

The strobe never appears in the first cycle of an access, while the address is still settling. It covers the whole wait cycle, across the `phi2` rise in the middle. The peripheral therefore sees one long access with a full cycle of address setup in front of it. When `tail_en` is set as the access starts, the CPU is held for a further cycle. During the low half of that cycle the strobe is already released while the address and data stay valid. This gives the peripheral half a cycle of hold time and time to let go of the data bus. Accesses outside the decoded window run at full speed and produce no strobe.

The block has no data stream. Every pin is a plain level-sensitive control or status signal, so there is no valid/ready handshake and no back-pressure.

Top module: `periph_stretch`

## Requirements
- R1: While `rst_n` is low, `rdy` is 1, `oe_n` and `we_n` are 1 and `phi2` is 0.
- R2: `phi2` changes value on every `clk2x` rising edge after reset. The first edge after reset drives it to 1.
- R3: The peripheral is selected when `((addr ^ base) & mask) == 0`. This is evaluated only at the `clk2x` edge that raises `phi2` while no access is in progress.
- R4: For a selected access without tail, `rdy` is 0 for exactly two `clk2x` periods: the high half of the first cycle and the low half of the wait cycle. The CPU finishes on the `phi2` fall that ends the wait cycle.
- R5: Each selected access gives exactly one strobe pulse of exactly two `clk2x` periods. The pulse is unbroken across the `phi2` rise inside the wait cycle.
- R6: A strobe only begins at a `phi2` falling edge, the one that ends the first cycle. No strobe occurs in the decode cycle.
- R7: `rw`=1 at the decode edge gives an `oe_n` pulse and `rw`=0 gives a `we_n` pulse. The two are never low together.
- R8: Changes on `addr` and `rw` after the decode edge have no effect on the running access. The strobe kind and the `rdy` timing stay as latched.
- R9: An unselected access gets no wait state (`rdy` stays 1) and no strobe.
- R10: With `tail_en`=1 at the decode edge, the strobe timing is unchanged. `rdy` then stays 0 until the low half of the following cycle has passed with both strobes high, and returns to 1 for that cycle's high half.
- R11: The cycle right after a completed access is decoded afresh, so back-to-back peripheral accesses each get their own wait state and strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x | input | 1 | Clock at twice the CPU cycle rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | CPU address bus |
| rw | input | 1 | 1 = read, 0 = write |
| base | input | AW | Decode base address of the peripheral window |
| mask | input | AW | Address bits compared by the decode (1 = compared) |
| tail_en | input | 1 | Adds the half-cycle hold phase after the strobe |
| phi2 | output | 1 | Generated CPU phase clock |
| rdy | output | 1 | Active-high ready to the CPU; 0 stretches the cycle |
| oe_n | output | 1 | Active-low peripheral output enable |
| we_n | output | 1 | Active-low peripheral write enable |

## Verification
A behavioural CPU model presents a series of bus operations and holds each one while the expected ready level is low. Every output is compared on every half cycle.

Reads and writes inside the window check that the strobe kind follows the latched direction. Addresses just outside the mask, and just below the base, check that the decode does not over-match. A changed mask checks that the decode follows the programmed pattern. Runs with and without the tail separate the two completion timings. Back-to-back selected accesses check that no decode is missed after a completion. Operations that corrupt `addr` and `rw` in the middle of the wait cycle show whether the latched state is really the one in use.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

  // Half-cycle positions of one peripheral access.
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,  // no access running
    ST_SETUP   = 3'd1,  // high half of the decode cycle
    ST_STRB_LO = 3'd2,  // low half of the wait cycle, strobe on
    ST_STRB_HI = 3'd3,  // high half of the wait cycle, strobe on
    ST_TAIL_LO = 3'd4,  // hold half, strobe off
    ST_TAIL_HI = 3'd5   // completing half after the hold
  } seq_t;

  function automatic logic strobe_of(seq_t s);
    return (s == ST_STRB_LO) || (s == ST_STRB_HI);
  endfunction

  function automatic logic ready_of(seq_t s, logic tail);
    case (s)
      ST_SETUP, ST_STRB_LO, ST_TAIL_LO: return 1'b0;
      ST_STRB_HI:                       return ~tail;
      default:                          return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/wsg_phase.sv
module wsg_phase (
  input  logic clk2x,
  input  logic rst_n,
  output logic phi2,
  output logic rise_next
);

  logic phi2_q;

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) phi2_q <= 1'b0;
    else        phi2_q <= ~phi2_q;
  end

  assign phi2      = phi2_q;
  assign rise_next = ~phi2_q;  // the coming edge raises phi2

  assert_phase_toggles_R2: assert property (@(posedge clk2x) disable iff (!rst_n)
    $past(rst_n) |-> (phi2_q != $past(phi2_q)));

endmodule

// File: rtl/wsg_decode.sv
module wsg_decode #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] mask,
  output logic          hit
);

  logic [AW-1:0] diff;

  always_comb begin
    diff = (addr ^ base) & mask;
    hit  = (diff == '0);
  end

endmodule

// File: rtl/wsg_seq.sv
module wsg_seq
  import wsg_pkg::*;
(
  input  logic clk2x,
  input  logic rst_n,
  input  logic phi2,
  input  logic rise_next,
  input  logic hit,
  input  logic rw,
  input  logic tail_en,
  output logic rdy,
  output logic oe_n,
  output logic we_n
);

  seq_t state_q, state_d;
  logic rd_q, rd_d;
  logic tail_q, tail_d;
  logic rdy_q, oe_n_q, we_n_q;
  logic strb_d;
  logic strb_n;

  always_comb begin
    state_d = state_q;
    rd_d    = rd_q;
    tail_d  = tail_q;
    unique case (state_q)
      ST_IDLE: begin
        rd_d   = rw;
        tail_d = tail_en;
        if (rise_next && hit) state_d = ST_SETUP;
      end
      ST_SETUP:   state_d = ST_STRB_LO;
      ST_STRB_LO: state_d = ST_STRB_HI;
      ST_STRB_HI: state_d = tail_q ? ST_TAIL_LO : ST_IDLE;
      ST_TAIL_LO: state_d = ST_TAIL_HI;
      ST_TAIL_HI: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
    strb_d = strobe_of(state_d);
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rd_q    <= 1'b1;
      tail_q  <= 1'b0;
      rdy_q   <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      rd_q    <= rd_d;
      tail_q  <= tail_d;
      rdy_q   <= ready_of(state_d, tail_d);
      oe_n_q  <= ~(strb_d & rd_d);
      we_n_q  <= ~(strb_d & ~rd_d);
    end
  end

  assign rdy    = rdy_q;
  assign oe_n   = oe_n_q;
  assign we_n   = we_n_q;
  assign strb_n = oe_n_q & we_n_q;

  assert_one_strobe_R7: assert property (@(posedge clk2x) disable iff (!rst_n)
    !(!oe_n_q && !we_n_q));

  assert_strobe_starts_on_fall_R6: assert property (@(posedge clk2x) disable iff (!rst_n)
    $fell(strb_n) |-> !phi2);

  assert_strobe_unbroken_R5: assert property (@(posedge clk2x) disable iff (!rst_n)
    $fell(strb_n) |=> !strb_n);

  assert_strobe_two_periods_R5: assert property (@(posedge clk2x) disable iff (!rst_n)
    $fell(strb_n) |-> ##2 strb_n);

  assert_wait_starts_on_rise_R4: assert property (@(posedge clk2x) disable iff (!rst_n)
    $fell(rdy_q) |-> (phi2 && strb_n));

  assert_wait_spans_two_R4: assert property (@(posedge clk2x) disable iff (!rst_n)
    $fell(rdy_q) |=> !rdy_q);

  assert_release_plain_R4: assert property (@(posedge clk2x) disable iff (!rst_n)
    ($rose(strb_n) && !tail_q) |-> rdy_q);

  assert_release_tail_R10: assert property (@(posedge clk2x) disable iff (!rst_n)
    ($rose(strb_n) && tail_q) |-> !rdy_q);

endmodule

// File: rtl/periph_stretch.sv
module periph_stretch #(
  parameter int AW = 16
) (
  input  logic          clk2x,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          rw,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] mask,
  input  logic          tail_en,
  output logic          phi2,
  output logic          rdy,
  output logic          oe_n,
  output logic          we_n
);

  logic rise_next;
  logic hit;

  wsg_phase u_phase (
    .clk2x     (clk2x),
    .rst_n     (rst_n),
    .phi2      (phi2),
    .rise_next (rise_next)
  );

  wsg_decode #(.AW(AW)) u_decode (
    .addr (addr),
    .base (base),
    .mask (mask),
    .hit  (hit)
  );

  wsg_seq u_seq (
    .clk2x     (clk2x),
    .rst_n     (rst_n),
    .phi2      (phi2),
    .rise_next (rise_next),
    .hit       (hit),
    .rw        (rw),
    .tail_en   (tail_en),
    .rdy       (rdy),
    .oe_n      (oe_n),
    .we_n      (we_n)
  );

endmodule

// File: tb/periph_stretch_tb.sv
module periph_stretch_tb;

  localparam int AW   = 16;
  localparam int NOPS = 13;

  logic          clk2x   = 1'b0;
  logic          rst_n   = 1'b0;
  logic [AW-1:0] addr    = '0;
  logic [AW-1:0] base    = 16'h8000;
  logic [AW-1:0] mask    = 16'hFFF0;
  logic          rw      = 1'b1;
  logic          tail_en = 1'b0;
  logic          phi2, rdy, oe_n, we_n;

  always #4 clk2x = ~clk2x;  // 125 MHz

  periph_stretch #(.AW(AW)) u_dut (
    .clk2x (clk2x), .rst_n (rst_n), .addr (addr), .rw (rw),
    .base (base), .mask (mask), .tail_en (tail_en),
    .phi2 (phi2), .rdy (rdy), .oe_n (oe_n), .we_n (we_n)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [AW-1:0] op_addr [NOPS];
  logic [AW-1:0] op_mask [NOPS];
  logic          op_rw   [NOPS];
  logic          op_tail [NOPS];
  logic          op_glt  [NOPS];
  string         op_tag  [NOPS];

  task automatic chk(input bit ok, input string req, input string what,
                     input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d", req, what, got, exp);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic set_op(input int i, input logic [AW-1:0] a, input logic [AW-1:0] m,
                        input logic r, input logic t, input logic g, input string tag);
    op_addr[i] = a; op_mask[i] = m; op_rw[i] = r;
    op_tail[i] = t; op_glt[i]  = g; op_tag[i] = tag;
  endtask

  // Reference model state
  int    stage = 0;
  bit    m_phi2 = 0, m_rd = 1, m_tail = 0, m_rdy = 1, prev_rdy;
  bit    exp_strb, cur_strb;
  int    run_len = 0;
  int    idx = -1;
  int    idle_cnt = 0;
  string tag;

  initial begin
    set_op(0,  16'h8003, 16'hFFF0, 1'b1, 1'b0, 1'b0, "R3 R4 R7 read");
    set_op(1,  16'h8005, 16'hFFF0, 1'b0, 1'b0, 1'b0, "R5 R7 write");
    set_op(2,  16'h1234, 16'hFFF0, 1'b1, 1'b0, 1'b0, "R9 ram read");
    set_op(3,  16'h7FFF, 16'hFFF0, 1'b0, 1'b0, 1'b0, "R9 below base");
    set_op(4,  16'h800F, 16'hFFF0, 1'b1, 1'b1, 1'b0, "R10 tail read");
    set_op(5,  16'h8000, 16'hFFF0, 1'b0, 1'b1, 1'b0, "R10 tail write");
    set_op(6,  16'h8001, 16'hFFF0, 1'b1, 1'b0, 1'b0, "R11 back-to-back 1");
    set_op(7,  16'h8002, 16'hFFF0, 1'b0, 1'b0, 1'b0, "R11 back-to-back 2");
    set_op(8,  16'h8004, 16'hFFF0, 1'b1, 1'b0, 1'b1, "R8 corrupt read");
    set_op(9,  16'h8006, 16'hFFF0, 1'b0, 1'b1, 1'b1, "R8 corrupt write");
    set_op(10, 16'h8010, 16'hFFF0, 1'b1, 1'b0, 1'b0, "R3 outside mask");
    set_op(11, 16'h80AB, 16'hFF00, 1'b1, 1'b0, 1'b0, "R3 wide mask hit");
    set_op(12, 16'h81AB, 16'hFF00, 1'b0, 1'b0, 1'b0, "R3 wide mask miss");

    repeat (3) @(negedge clk2x);
    chk(rdy == 1'b1, "R1", "reset rdy", int'(rdy), 1);
    chk(oe_n == 1'b1 && we_n == 1'b1, "R1", "reset strobes", int'({oe_n, we_n}), 3);
    chk(phi2 == 1'b0, "R1", "reset phi2", int'(phi2), 0);
    rst_n = 1'b1;

    while (!done) begin
      @(negedge clk2x);
      prev_rdy = m_rdy;
      // model the edge that just happened, with the inputs that were present
      if (stage == 0) begin
        if (!m_phi2 && (((addr ^ base) & mask) == '0)) begin
          stage = 1; m_rd = rw; m_tail = tail_en;
        end
      end else if ((stage == 3 && !m_tail) || stage == 5) begin
        stage = 0;
      end else begin
        stage++;
      end
      m_phi2   = !m_phi2;
      m_rdy    = !(stage == 1 || stage == 2 || stage == 4 || (stage == 3 && m_tail));
      exp_strb = (stage == 2 || stage == 3);
      tag = (idx >= 0 && idx < NOPS) ? op_tag[idx] : "idle";

      chk(phi2 == m_phi2, "R2", "phi2", int'(phi2), int'(m_phi2));
      chk(rdy == m_rdy, tag, "rdy (R4)", int'(rdy), int'(m_rdy));
      chk(oe_n == !(exp_strb && m_rd), tag, "oe_n (R7)", int'(oe_n), int'(!(exp_strb && m_rd)));
      chk(we_n == !(exp_strb && !m_rd), tag, "we_n (R7)", int'(we_n), int'(!(exp_strb && !m_rd)));
      chk(!(!oe_n && !we_n), "R7", "both strobes low", int'({oe_n, we_n}), 1);

      cur_strb = !oe_n || !we_n;
      if (cur_strb && run_len == 0)
        chk(phi2 == 1'b0 && prev_rdy == 1'b0, "R6", "strobe start phase", int'(phi2), 0);
      if (cur_strb) run_len++;
      else if (run_len > 0) begin
        chk(run_len == 2, "R5", "strobe length", run_len, 2);
        run_len = 0;
      end

      // CPU side: corrupt inputs in the wait cycle, advance on completion
      if (stage == 2 && idx >= 0 && idx < NOPS && op_glt[idx]) begin
        rw = !rw; addr = '0;
      end
      if (!m_phi2 && prev_rdy) begin
        idx++;
        if (idx < NOPS) begin
          addr = op_addr[idx]; mask = op_mask[idx];
          rw = op_rw[idx]; tail_en = op_tail[idx];
        end else begin
          addr = '0; rw = 1'b1; tail_en = 1'b0;
          idle_cnt++;
          if (idle_cnt > 4) done = 1;
        end
      end
    end
    chk(run_len == 0, "R5", "strobe left asserted", run_len, 0);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk2x);
    if (!done) begin
      errors++;
      $display("FAIL R4 watchdog got hang exp completion");
      report();
    end
  end

endmodule